// File: doc/BRIEF.md
# Card Interface Power Sequencer

This block sets the power state of a memory-card host interface from a small control register. A 2-bit mode field selects one of three states for the card clock, command and data pads. In the first, every line is pulled low so the card cannot draw supply through its signal pins. In the second, the lines are held high while the host stays disabled. In the third, the lines are handed to the functional path. Three further register bits request a voltage switch, enable voltage switching and select the polarity of the external direction signals. These bits are stored and brought out, but the block does nothing else with them.

Once the field enters the power-on state, the card clock runs, but the command and data engines are held off for a fixed number of card-clock edges (74 by default). The sequencer counts those edges on a one-cycle tick input and then raises a host-enable output. After a reset every pad is in high impedance until software writes the register for the first time. The reset value of the field is the same as the power-off encoding.

Top module: `card_pwr_seq`

## Requirements
- R1: In the cycle after a synchronous reset, `rdata` reads 0, every line has `line_oe` low (high impedance) and `host_en` is low. This lasts until the first write.
- R2: Writing mode 00 (bits 1:0) sets, for every line, `line_oe`=1, `line_force`=1 and `line_level`=1, and keeps `host_en` low.
- R3: Writing mode 10 sets, for every line, `line_oe`=1, `line_force`=1 and `line_level`=0, and keeps `host_en` low.
- R4: Writing mode 11 sets, for every line, `line_oe`=1, `line_force`=0 and `line_level`=0, so the functional path drives the pads.
- R5: Mode 01 is reserved. Its pad outputs equal those of mode 00, and `rdata` reads back 01.
- R6: Bit 2 (`vsw_req`), bit 3 (`vsw_en`) and bit 4 (`dir_pol`) are stored on a write, read back at the same positions and drive the matching outputs. Bits above 4 read as zero.
- R7: `host_en` rises at the clock edge where the 74th `card_tick` is sampled in power-on. Ticks sampled on the edge of the write that enters power-on do not count, and after 73 ticks `host_en` is still low.
- R8: A write that leaves power-on drops `host_en` and clears the count on that same edge. A later entry into power-on needs a full 74 ticks again.
- R9: Writing mode 11 while already in power-on does not restart the count and does not drop `host_en`.
- R10: Register and pad outputs change on the clock edge of the write and not before. A cycle with `wr_en` low changes nothing.
- R11: If a write that leaves power-on falls on the same edge as the 74th tick, `host_en` stays low.

Each requirement fixes the pad state, the readback or `host_en` on the edge of the write or tick that triggers it, so every one can be checked directly at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | REG_W | Register write data |
| card_tick | input | 1 | One-cycle pulse per card-clock edge |
| rdata | output | REG_W | Register readback |
| line_oe | output | NUM_DATA+2 | Pad output enable per line (0 = high impedance); index 0 clock, 1 command, 2 and up data |
| line_force | output | NUM_DATA+2 | 1 = sequencer level overrides the functional path |
| line_level | output | NUM_DATA+2 | Level driven while forced |
| host_en | output | 1 | Enable for the command and data engines |
| vsw_req | output | 1 | Stored voltage-switch request bit |
| vsw_en | output | 1 | Stored voltage-switch enable bit |
| dir_pol | output | 1 | Stored direction-polarity bit |

## Verification
A write that leaves power-on can fall on the same edge as the tick that would finish the hold-off count. In that case the clear has to win. The bench provokes this by entering power-on and issuing 73 ticks. It then drives the 74th tick and a mode-10 write in the same cycle. It judges the result by checking that `host_en` stays low and the pads show the power-cycle levels, and that a fresh entry with only one tick does not enable the host.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;

  localparam int MODE_LSB    = 0;
  localparam int VSW_REQ_BIT = 2;
  localparam int VSW_EN_BIT  = 3;
  localparam int DIRPOL_BIT  = 4;
  localparam int CTRL_BITS   = 5;

  typedef enum logic [1:0] {
    PM_OFF   = 2'b00,
    PM_RSVD  = 2'b01,
    PM_CYCLE = 2'b10,
    PM_ON    = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    DRV_HIZ  = 2'b00,
    DRV_LOW  = 2'b01,
    DRV_HIGH = 2'b10,
    DRV_FUNC = 2'b11
  } drive_e;

  // Pads stay floating until the first write; reserved mode behaves as off.
  function automatic drive_e mode_to_drive(input logic live, input logic [1:0] mode);
    drive_e d;
    if (!live) d = DRV_HIZ;
    else begin
      case (mode)
        PM_CYCLE: d = DRV_LOW;
        PM_ON:    d = DRV_FUNC;
        default:  d = DRV_HIGH;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/card_pwr_regs.sv
module card_pwr_regs
  import card_pwr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wdata,
  output logic [CTRL_BITS-1:0] ctrl_q,
  output logic [CTRL_BITS-1:0] ctrl_d,
  output logic                 live_q,
  output logic                 live_d
);

  assign ctrl_d = wr_en ? wdata[CTRL_BITS-1:0] : ctrl_q;
  assign live_d = live_q | wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      live_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      live_q <= live_d;
    end
  end

endmodule

// File: rtl/card_pwr_holdoff.sv
module card_pwr_holdoff #(
  parameter int HOLDOFF_CYCLES = 74
) (
  input  logic clk,
  input  logic rst,
  input  logic on_q,
  input  logic on_d,
  input  logic tick,
  output logic enable
);

  localparam int CW = $clog2(HOLDOFF_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !on_d) begin
      cnt    <= '0;
      enable <= 1'b0;
    end else if (on_q && tick && !enable) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) enable <= 1'b1;
    end
  end

endmodule

// File: rtl/card_pwr_pads.sv
module card_pwr_pads
  import card_pwr_pkg::*;
#(
  parameter int NUM_LINES = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  drive_e               drv_d,
  output logic [NUM_LINES-1:0] oe,
  output logic [NUM_LINES-1:0] force_en,
  output logic [NUM_LINES-1:0] level
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        oe[i]       <= 1'b0;
        force_en[i] <= 1'b0;
        level[i]    <= 1'b0;
      end else begin
        oe[i]       <= (drv_d != DRV_HIZ);
        force_en[i] <= (drv_d == DRV_LOW) || (drv_d == DRV_HIGH);
        level[i]    <= (drv_d == DRV_HIGH);
      end
    end
  end

endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import card_pwr_pkg::*;
#(
  parameter int REG_W          = 8,
  parameter int NUM_DATA       = 8,
  parameter int HOLDOFF_CYCLES = 74
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wdata,
  input  logic                  card_tick,
  output logic [REG_W-1:0]      rdata,
  output logic [NUM_DATA+1:0]   line_oe,
  output logic [NUM_DATA+1:0]   line_force,
  output logic [NUM_DATA+1:0]   line_level,
  output logic                  host_en,
  output logic                  vsw_req,
  output logic                  vsw_en,
  output logic                  dir_pol
);

  localparam int NUM_LINES = NUM_DATA + 2;

  logic [CTRL_BITS-1:0] ctrl_q, ctrl_d;
  logic                 live_q, live_d;
  logic                 on_q, on_d;
  drive_e               drv_d;

  card_pwr_regs #(.REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .ctrl_q (ctrl_q),
    .ctrl_d (ctrl_d),
    .live_q (live_q),
    .live_d (live_d)
  );

  assign on_q  = live_q && (ctrl_q[MODE_LSB+:2] == PM_ON);
  assign on_d  = live_d && (ctrl_d[MODE_LSB+:2] == PM_ON);
  assign drv_d = mode_to_drive(live_d, ctrl_d[MODE_LSB+:2]);

  card_pwr_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .on_q   (on_q),
    .on_d   (on_d),
    .tick   (card_tick),
    .enable (host_en)
  );

  card_pwr_pads #(.NUM_LINES(NUM_LINES)) u_pads (
    .clk      (clk),
    .rst      (rst),
    .drv_d    (drv_d),
    .oe       (line_oe),
    .force_en (line_force),
    .level    (line_level)
  );

  assign rdata   = REG_W'(ctrl_q);
  assign vsw_req = ctrl_q[VSW_REQ_BIT];
  assign vsw_en  = ctrl_q[VSW_EN_BIT];
  assign dir_pol = ctrl_q[DIRPOL_BIT];

endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk #(
  parameter int REG_W          = 8,
  parameter int NUM_DATA       = 8,
  parameter int HOLDOFF_CYCLES = 74
) (
  input logic                clk,
  input logic                rst,
  input logic                card_tick,
  input logic [REG_W-1:0]    rdata,
  input logic [NUM_DATA+1:0] line_oe,
  input logic [NUM_DATA+1:0] line_force,
  input logic [NUM_DATA+1:0] line_level,
  input logic                host_en
);

  localparam int CW = $clog2(HOLDOFF_CYCLES + 2);
  logic [CW-1:0] seen;
  logic          mode_on;

  assign mode_on = (rdata[1:0] == 2'b11) && (&line_oe);

  // Independent tally of ticks spent in power-on, saturating.
  always_ff @(posedge clk) begin
    if (rst || !mode_on) seen <= '0;
    else if (card_tick && seen != CW'(HOLDOFF_CYCLES)) seen <= seen + 1'b1;
  end

  a_r1_reset_hiz: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_oe == '0 && !host_en && rdata == '0));

  a_r3_cycle_low: assert property (@(posedge clk) disable iff (rst)
    (rdata[1:0] == 2'b10 && |line_oe) |-> (&line_force && line_level == '0 && !host_en));

  a_r4_on_func: assert property (@(posedge clk) disable iff (rst)
    (rdata[1:0] == 2'b11 && |line_oe) |-> (line_force == '0));

  a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(host_en) |-> ($past(card_tick) && seen == CW'(HOLDOFF_CYCLES)));

  a_r8_only_in_on: assert property (@(posedge clk) disable iff (rst)
    host_en |-> mode_on);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    host_en |=> (host_en || !mode_on));

endmodule

bind card_pwr_seq card_pwr_seq_chk #(
  .REG_W(REG_W), .NUM_DATA(NUM_DATA), .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .card_tick(card_tick), .rdata(rdata),
  .line_oe(line_oe), .line_force(line_force), .line_level(line_level),
  .host_en(host_en)
);

// File: tb/card_pwr_seq_bench.sv
module card_pwr_seq_bench;

  localparam int REG_W = 8;
  localparam int ND    = 8;
  localparam int HOLD  = 74;
  localparam int NL    = ND + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wdata = '0;
  logic             card_tick = 1'b0;
  logic [REG_W-1:0] rdata;
  logic [NL-1:0]    line_oe, line_force, line_level;
  logic             host_en, vsw_req, vsw_en, dir_pol;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  card_pwr_seq #(.REG_W(REG_W), .NUM_DATA(ND), .HOLDOFF_CYCLES(HOLD)) u_card_pwr_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .card_tick(card_tick),
    .rdata(rdata), .line_oe(line_oe), .line_force(line_force), .line_level(line_level),
    .host_en(host_en), .vsw_req(vsw_req), .vsw_en(vsw_en), .dir_pol(dir_pol)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Pads as {oe, force, level}, each a full line vector.
  task automatic check_pads(input string req, input logic oe, input logic frc, input logic lvl);
    check({req, " oe"},    32'(line_oe),    32'({NL{oe}}));
    check({req, " force"}, 32'(line_force), 32'({NL{frc}}));
    check({req, " level"}, 32'(line_level), 32'({NL{lvl}}));
  endtask

  task automatic wr(input logic [REG_W-1:0] d, input logic tk);
    @(negedge clk);
    wr_en = 1'b1; wdata = d; card_tick = tk;
    @(negedge clk);
    wr_en = 1'b0; card_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); card_tick = 1'b1;
      @(negedge clk); card_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata", 32'(rdata), 0);
    check("R1 oe", 32'(line_oe), 0);
    check("R1 host_en", 32'(host_en), 0);
  endtask

  task automatic t_sequence;
    wr(8'h00, 1'b0);
    check_pads("R2 off", 1, 1, 1);
    check("R2 host_en", 32'(host_en), 0);
    wr(8'h02, 1'b0);
    check_pads("R3 cycle", 1, 1, 0);
    check("R3 rdata", 32'(rdata), 32'h2);
    wr(8'h00, 1'b0);
    check_pads("R2 off again", 1, 1, 1);
    wr(8'h03, 1'b1);  // tick on the entry edge must not count
    check_pads("R4 on", 1, 0, 0);
    ticks(HOLD - 1);
    check("R7 after 73 ticks", 32'(host_en), 0);
    @(negedge clk);
    check("R7 idle cycle no enable", 32'(host_en), 0);
    ticks(1);
    check("R7 after 74th tick", 32'(host_en), 1);
  endtask

  task automatic t_rewrite_on;
    wr(8'h03, 1'b0);
    check("R9 rewrite on keeps enable", 32'(host_en), 1);
    ticks(3);
    check("R9 still enabled", 32'(host_en), 1);
  endtask

  task automatic t_leave_reenter;
    wr(8'h02, 1'b0);
    check("R8 leave drops enable", 32'(host_en), 0);
    check_pads("R8 cycle pads", 1, 1, 0);
    wr(8'h03, 1'b0);
    ticks(HOLD - 1);
    check("R8 reentry 73 ticks", 32'(host_en), 0);
    ticks(1);
    check("R8 reentry 74 ticks", 32'(host_en), 1);
  endtask

  task automatic t_reserved;
    wr(8'h01, 1'b0);
    check_pads("R5 reserved as off", 1, 1, 1);
    check("R5 readback", 32'(rdata), 32'h1);
    check("R5 host_en", 32'(host_en), 0);
  endtask

  task automatic t_bits;
    wr(8'hFC, 1'b0);
    check("R6 readback", 32'(rdata), 32'h1C);
    check("R6 outputs", 32'({vsw_req, vsw_en, dir_pol}), 32'h7);
    check_pads("R6 mode off", 1, 1, 1);
    wr(8'h10, 1'b0);
    check("R6 dir only", 32'({vsw_req, vsw_en, dir_pol}), 32'h1);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    wdata = 8'h03; wr_en = 1'b0;
    @(negedge clk);
    check("R10 no strobe rdata", 32'(rdata), 32'h10);
    check_pads("R10 no strobe pads", 1, 1, 1);
    // Pads must still be old until the write edge.
    wr_en = 1'b1; wdata = 8'h02;
    @(posedge clk); #1;
    check_pads("R10 on write edge", 1, 1, 0);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_collide;
    wr(8'h03, 1'b0);
    ticks(HOLD - 1);
    check("R11 pre", 32'(host_en), 0);
    wr(8'h02, 1'b1);
    check("R11 clear wins", 32'(host_en), 0);
    check_pads("R11 cycle pads", 1, 1, 0);
    wr(8'h03, 1'b0);
    ticks(1);
    check("R11 fresh count", 32'(host_en), 0);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_rewrite_on();
    t_leave_reenter();
    t_reserved();
    t_bits();
    t_ignore();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule